// File: doc/BRIEF.md
# Two-Stage Prescaled PWM Generator

This block makes a pulse-width-modulated waveform from one source clock, using two timers in series. The first stage is a reloading down-counter that sets the time base. Each time it reloads, it flips a tick output, so one full tick period covers two reloads. The second stage is an 8-bit dual-phase timer. It advances once on every tick transition, rising or falling. It alternates between a high phase and a low phase, and each phase has its own programmed length.

One packed 16-bit compare word holds both phase lengths, so the period and the duty are set together. To change the output frequency without touching the duty, change only the prescale compare. Software normally writes both compares while the enable is low and then raises the enable. The block also accepts new values while it runs, and applies them only at safe boundaries.

Top module: `chained_pwm_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `pwm_out` and `tick_out` are low after that edge, whatever the value of `en`.
- R2: While `en` is sampled low, both outputs are low from the next clock on, and neither counter advances.
- R3: On the first clock edge that samples `en` high after it was low, both stages load their compares. From that edge on, `pwm_out` is high and `tick_out` is low.
- R4: With prescale compare P, `tick_out` stays at each level for exactly P+1 clocks, which gives a tick period of 2·(P+1) clocks.
- R5: Each tick transition, rising or falling, advances the PWM stage by exactly one step, so one step lasts P+1 clocks.
- R6: The high phase lasts (`pwm_cmp[7:0]`+1) steps. The low phase lasts (`pwm_cmp[15:8]`+1) steps. A new period then starts with a high phase.
- R7: A compare word of 0x13B3 gives 180 high steps and 20 low steps, which is 90% of a 200-step period. A compare word of 0xB313 gives 10%.
- R8: Changing `presc_cmp` while running takes effect at the next prescaler reload. From then on the phase lengths in clocks scale with the new step length, and the step counts stay the same.
- R9: Changing `pwm_cmp` while running does not change the period in progress. Both new phase lengths take effect from the next high-phase start.
- R10: A phase-length byte of 0 gives a one-step phase, so the output keeps toggling.
- R11: Dropping `en` while running forces both outputs low on the next clock. Raising it again restarts a full high phase from a freshly loaded state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock for both stages |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Global run enable |
| presc_cmp | input | 16 | Prescaler reload value P; one step is P+1 clocks |
| pwm_cmp | input | 16 | [7:0] high-phase length minus one, [15:8] low-phase length minus one |
| pwm_out | output | 1 | PWM waveform |
| tick_out | output | 1 | Prescaler tick, toggling at each reload |

## Verification
The hardest cases to reach from the ports are compare writes that land in the middle of a running phase or a running step. Only the boundary rules decide what happens to them. The stimulus first waits until it sees a `pwm_out` rising edge. A fixed number of falling edges later, it writes a new value, so the write lands inside a known high phase. It then measures the rest of that period and the whole next period, level by level. For a prescale change, the bench discards the mixed period that straddles the change and checks the first period made entirely of new steps.

// File: rtl/cpt_pkg.sv
// Package: shared types for the two-stage prescaled PWM generator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package cpt_pkg;

    // Phase of the PWM stage.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Default widths for the prescaler and for one phase-length field.
    localparam int DEF_PRESC_W = 16;
    localparam int DEF_PHASE_W = 8;

endpackage : cpt_pkg

// File: rtl/cpt_prescaler.sv
// Module: cpt_prescaler
// Reloading down-counter. When it reaches zero it reloads from reload_val and
// flips tick. The step strobe is high in the cycle that ends with a reload,
// which is exactly the cycle before each tick transition, rising or falling.
// Assumes: start and run are mutually exclusive (start only while run is low).
module cpt_prescaler #(
    parameter int CNT_W = cpt_pkg::DEF_PRESC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] reload_val,
    output logic             tick,
    output logic             step
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Strobe marking the reload edge, which is also the next tick transition.
    assign step = run && (cnt_q == ZERO);

    // Down-count, reload at zero and flip the tick; hold while not running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
            tick  <= 1'b0;
        end else if (start) begin
            cnt_q <= reload_val;
            tick  <= 1'b0;
        end else if (run) begin
            if (cnt_q == ZERO) begin
                cnt_q <= reload_val;
                tick  <= ~tick;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

endmodule : cpt_prescaler

// File: rtl/cpt_pwm_core.sv
// Module: cpt_pwm_core
// Dual-phase PWM timer that advances once per step strobe. The high phase
// lasts (high length + 1) steps and the low phase (low length + 1) steps.
// Both lengths are sampled from the packed compare word when a period starts;
// the low length is kept in a shadow register so a mid-period write never
// changes the period in progress.
// Assumes: step is only high while the block is running.
module cpt_pwm_core #(
    parameter int PHASE_W = cpt_pkg::DEF_PHASE_W,
    localparam int CMP_W  = 2 * PHASE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic [CMP_W-1:0] cmp,
    output logic             phase_high
);

    import cpt_pkg::*;

    localparam logic [PHASE_W-1:0] ZERO = '0;
    localparam logic [PHASE_W-1:0] ONE  = {{(PHASE_W-1){1'b0}}, 1'b1};

    logic [PHASE_W-1:0] hi_len;
    logic [PHASE_W-1:0] lo_len;
    logic [PHASE_W-1:0] cnt_q;
    logic [PHASE_W-1:0] lo_shadow_q;
    phase_e             ph_q;

    // Split the packed compare word into the two phase-length fields.
    assign hi_len = cmp[PHASE_W-1:0];
    assign lo_len = cmp[CMP_W-1:PHASE_W];

    // Count down the current phase and switch phase after its last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= ZERO;
            lo_shadow_q <= ZERO;
            ph_q        <= PH_LOW;
        end else if (start) begin
            cnt_q       <= hi_len;
            lo_shadow_q <= lo_len;
            ph_q        <= PH_HIGH;
        end else if (step) begin
            if (cnt_q == ZERO) begin
                if (ph_q == PH_HIGH) begin
                    ph_q  <= PH_LOW;
                    cnt_q <= lo_shadow_q;
                end else begin
                    ph_q        <= PH_HIGH;
                    cnt_q       <= hi_len;
                    lo_shadow_q <= lo_len;
                end
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    // Report the current phase level.
    assign phase_high = (ph_q == PH_HIGH);

endmodule : cpt_pwm_core

// File: rtl/chained_pwm_timer.sv
// Module: chained_pwm_timer (top)
// Two cascaded timers on one clock. The prescaler sets the step length, and
// the PWM stage counts one step per prescaler tick transition. The enable is
// registered into a run flag; the cycle in which the enable is seen while the
// run flag is clear loads both stages. Both outputs are gated low while the
// block is not running.
// Assumes: compares are normally written while en is low; writes made while
// running are applied at the next reload boundary of the stage concerned.
module chained_pwm_timer #(
    parameter int PRESC_W = cpt_pkg::DEF_PRESC_W,
    parameter int PHASE_W = cpt_pkg::DEF_PHASE_W,
    localparam int CMP_W  = 2 * PHASE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PRESC_W-1:0] presc_cmp,
    input  logic [CMP_W-1:0]   pwm_cmp,
    output logic               pwm_out,
    output logic               tick_out
);

    logic run_q;
    logic start;
    logic presc_tick;
    logic presc_step;
    logic phase_high;

    // Register the enable into the run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= en;
        end
    end

    // Load pulse on the first enabled cycle.
    assign start = en && !run_q;

    cpt_prescaler #(
        .CNT_W (PRESC_W)
    ) presc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .run        (run_q),
        .reload_val (presc_cmp),
        .tick       (presc_tick),
        .step       (presc_step)
    );

    cpt_pwm_core #(
        .PHASE_W (PHASE_W)
    ) pwm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .step       (presc_step),
        .cmp        (pwm_cmp),
        .phase_high (phase_high)
    );

    // Gate both outputs with the run flag.
    assign pwm_out  = run_q && phase_high;
    assign tick_out = run_q && presc_tick;

endmodule : chained_pwm_timer

// File: rtl/cpt_checker.sv
// Module: cpt_checker
// Temporal checks for chained_pwm_timer, attached with the bind below.
// Assumes: en is driven to a known value from time zero.
module cpt_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic run,
    input logic step,
    input logic pwm_out,
    input logic tick_out
);

    // R2 / R11: a low enable forces both outputs low on the next cycle
    a_r2_off_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!pwm_out && !tick_out));

    // R3: the first enabled cycle starts with the PWM output high
    a_r3_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && !$past(en, 2)) |-> pwm_out);

    // R3: the first enabled cycle starts with the tick low
    a_r3_start_tick_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en) && !$past(en, 2)) |-> !tick_out);

    // R4: while running, the tick changes only after a reload strobe
    a_r4_tick_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (tick_out != $past(tick_out))) |-> $past(step));

    // R5: while running, the PWM output changes only after a step
    a_r5_pwm_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (pwm_out != $past(pwm_out))) |-> $past(step));

endmodule : cpt_checker

bind chained_pwm_timer cpt_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .run      (run_q),
    .step     (presc_step),
    .pwm_out  (pwm_out),
    .tick_out (tick_out)
);

// File: tb/chained_pwm_timer_tb_top.sv
// Bench for chained_pwm_timer: a vector table walked by one loop, then
// directed tests for reset, tick period and compare changes made while running.
module chained_pwm_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] presc_cmp = '0;
    logic [15:0] pwm_cmp = '0;
    logic        pwm_out;
    logic        tick_out;

    always #5 clk = ~clk;

    chained_pwm_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .presc_cmp (presc_cmp),
        .pwm_cmp   (pwm_cmp),
        .pwm_out   (pwm_out),
        .tick_out  (tick_out)
    );

    // Vector = {prescale P, compare word, expected high clocks, expected low clocks}
    localparam int NV = 8;
    localparam logic [63:0] VEC [NV] = '{
        {16'd0,  16'h13B3, 16'd180, 16'd20 },
        {16'd0,  16'hB313, 16'd20,  16'd180},
        {16'd3,  16'h13B3, 16'd720, 16'd80 },
        {16'd3,  16'hB313, 16'd80,  16'd720},
        {16'd19, 16'h0909, 16'd200, 16'd200},
        {16'd0,  16'h0000, 16'd1,   16'd1  },
        {16'd2,  16'h00FF, 16'd768, 16'd3  },
        {16'd1,  16'hFF00, 16'd2,   16'd512}
    };

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    // Count falling edges while the chosen output stays at lvl
    task automatic count_lvl(input bit use_tick, input bit lvl, output int n);
        n = 0;
        while ((use_tick ? tick_out : pwm_out) === lvl) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Stop, load compares, then enable; returns at the first enabled falling edge
    task automatic restart(input logic [15:0] p, input logic [15:0] c);
        @(negedge clk);
        en = 1'b0;
        presc_cmp = p;
        pwm_cmp = c;
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int h;
        int l;
        logic [15:0] vp, vc, veh, vel;

        // R1: reset dominates even with the enable high
        en = 1'b1;
        presc_cmp = 16'd0;
        pwm_cmp = 16'h0101;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 pwm_out in reset", pwm_out, 0);
            check("R1 tick_out in reset", tick_out, 0);
        end
        en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2: disabled for a long stretch stays low
        for (int i = 0; i < 20; i++) @(negedge clk);
        check("R2 pwm_out idle", pwm_out, 0);
        check("R2 tick_out idle", tick_out, 0);

        // Vector walk: R3 start state, R5 R6 R7 R10 phase lengths
        for (int i = 0; i < NV; i++) begin
            {vp, vc, veh, vel} = VEC[i];
            @(negedge clk);
            en = 1'b0;
            presc_cmp = vp;
            pwm_cmp = vc;
            @(negedge clk);
            check("R2 pwm_out low while off", pwm_out, 0);
            en = 1'b1;
            @(negedge clk);
            check("R3 pwm_out high at start", pwm_out, 1);
            check("R3 tick_out low at start", tick_out, 0);
            count_lvl(1'b0, 1'b1, h);
            check("R5 R6 R7 R10 high clocks", h, int'(veh));
            count_lvl(1'b0, 1'b0, l);
            check("R5 R6 R7 R10 low clocks", l, int'(vel));
            check("R6 next period starts high", pwm_out, 1);
        end

        // R4: tick half-period is P+1 clocks
        restart(16'd4, 16'h0303);
        count_lvl(1'b1, 1'b0, l);
        check("R4 tick low clocks", l, 5);
        count_lvl(1'b1, 1'b1, h);
        check("R4 tick high clocks", h, 5);
        count_lvl(1'b1, 1'b0, l);
        check("R4 tick low clocks again", l, 5);

        // R9: compare write inside a high phase leaves the period intact
        restart(16'd0, 16'h0404);
        @(negedge clk);
        @(negedge clk);
        pwm_cmp = 16'h0209;
        count_lvl(1'b0, 1'b1, h);
        check("R9 current high kept", h + 2, 5);
        count_lvl(1'b0, 1'b0, l);
        check("R9 current low kept", l, 5);
        count_lvl(1'b0, 1'b1, h);
        check("R9 new high applied", h, 10);
        count_lvl(1'b0, 1'b0, l);
        check("R9 new low applied", l, 3);

        // R8: prescale change scales clocks, duty kept
        restart(16'd1, 16'h0303);
        count_lvl(1'b0, 1'b1, h);
        check("R8 high before change", h, 8);
        count_lvl(1'b0, 1'b0, l);
        check("R8 low before change", l, 8);
        presc_cmp = 16'd4;
        count_lvl(1'b0, 1'b1, h);
        count_lvl(1'b0, 1'b0, l);
        count_lvl(1'b0, 1'b1, h);
        check("R8 high after change", h, 20);
        count_lvl(1'b0, 1'b0, l);
        check("R8 low after change", l, 20);

        // R11: dropping the enable mid-run, then restarting
        restart(16'd2, 16'h0505);
        for (int i = 0; i < 7; i++) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R11 pwm_out low after disable", pwm_out, 0);
        check("R11 tick_out low after disable", tick_out, 0);
        for (int i = 0; i < 10; i++) @(negedge clk);
        check("R2 pwm_out stays low", pwm_out, 0);
        check("R2 tick_out stays low", tick_out, 0);
        en = 1'b1;
        @(negedge clk);
        check("R11 restart pwm_out high", pwm_out, 1);
        check("R11 restart tick_out low", tick_out, 0);
        count_lvl(1'b0, 1'b1, h);
        check("R11 full high after restart", h, 18);

        finish_run();
    end

endmodule : chained_pwm_timer_tb_top